// File: doc/BRIEF.md
# T1 Transmit Error Injector

This block sits in the outgoing path of a T1 framer, between payload and framing assembly and the line coder. Test software writes a small control word. A zero-to-one change on one of its request bits arms a single error of one kind. The block holds that request until the stream reaches a bit position where the error can go, applies it once, and then drops it. The error kinds are a bipolar violation, a corrupted CRC-6 bit, a corrupted terminal framing bit, a corrupted signalling framing bit, and a flipped payload bit.

The framer supplies strobes that mark which kind of bit is on the wire this cycle. Terminal framing bits are marked in both superframe (D4) and extended superframe (ESF) modes. In ESF mode the same strobe marks the framing pattern bits. A separate control bit holds a loss-of-signal mode. While it is one, the output carries only zeros, and the line coder is told to skip zero code suppression. The bipolar violation does not change any bit value. It goes out as a flag that goes with a mark, so the line coder can break the alternate-mark rule on that pulse.

Top module: `t1_err_inject`

## Requirements
- R1: A request is armed only when a write changes its control bit from 0 to 1. A write that leaves the bit at 1, leaves it at 0, or clears it has no effect on the output.
- R2: An armed bipolar violation request (control bit 0) raises `out_bpv` once, with the first later valid bit whose input value is 1. Bits with value 0 do not use it up.
- R3: A CRC-6 error request (control bit 1) inverts the next bit marked by `crc_stb`. It is armed only while `esf_mode` is 1. A request made in D4 mode is discarded, and a pending request is dropped when the mode leaves ESF.
- R4: A terminal framing error request (control bit 2) inverts the next bit marked by `fbit_stb`, in either mode.
- R5: A signalling framing error request (control bit 3) inverts the next bit marked by `sbit_stb`. It is armed only in D4 mode (`esf_mode` = 0). A request made in ESF mode is discarded and is not held.
- R6: A payload error request (control bit 4) inverts exactly one bit marked by `pay_stb`. Later payload bits pass unchanged.
- R7: Each armed request is used up exactly once. Several 0-to-1 changes before the target bit arrives still give one error.
- R8: While control bit 5 is 1, every valid output bit is 0, `out_bpv` is 0 and `out_zcs_off` is 1. Pending requests are held and are applied once the bit returns to 0.
- R9: Each valid input bit appears on `out_bit` with `out_vld` one clock later. After reset all outputs are 0 and nothing is pending.
- R10: Control bits 6 and 7 have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 8 | Control word value written |
| esf_mode | input | 1 | 1 = extended superframe, 0 = D4 superframe |
| bit_vld | input | 1 | A stream bit is present this cycle |
| bit_in | input | 1 | Stream bit value from the framer |
| fbit_stb | input | 1 | Current bit is a terminal framing / ESF pattern bit |
| sbit_stb | input | 1 | Current bit is a signalling framing bit |
| crc_stb | input | 1 | Current bit is a CRC-6 bit |
| pay_stb | input | 1 | Current bit is a payload bit |
| out_vld | output | 1 | Output bit is present |
| out_bit | output | 1 | Stream bit after error injection |
| out_bpv | output | 1 | Line coder must send this mark as a bipolar violation |
| out_zcs_off | output | 1 | Line coder must skip zero code suppression for this bit |

## Verification
The bench builds the block with its default parameters: an 8-bit control word and the registered output stage. With these values the one-cycle latency can be checked, and so can bits 6 and 7 of the control word, which must do nothing. The bench switches between D4 and ESF while requests are pending and while they are being made. This exercises discarded requests, requests dropped by a mode change, and requests held through loss of signal. It also sends zero-valued bits ahead of a pending violation to show that only a mark uses it up.

// File: rtl/t1ei_pkg.sv
// Shared constants for the T1 transmit error injector.
// Request indices double as control word bit positions.
package t1ei_pkg;
    localparam int CTL_W   = 8;
    localparam int NREQ    = 5;
    localparam int REQ_BPV = 0;
    localparam int REQ_CRC = 1;
    localparam int REQ_FT  = 2;
    localparam int REQ_FS  = 3;
    localparam int REQ_PAY = 4;
    localparam int CTL_LOS = 5;
    typedef logic [NREQ-1:0] req_vec_t;
endpackage

// File: rtl/t1ei_ctl_reg.sv
// Control word register with 0-to-1 transition detection.
// Assumes a write lasts one cycle; rise_o is valid only in that cycle.
module t1ei_ctl_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] ctl_o,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] ctl_q;

    // Bits that go from 0 to 1 on this write
    always_comb begin
        rise_o = we_i ? (wdata_i & ~ctl_q) : '0;
    end

    // Hold the last written control word
    always_ff @(posedge clk) begin
        if (!rst_n)    ctl_q <= '0;
        else if (we_i) ctl_q <= wdata_i;
    end

    assign ctl_o = ctl_q;

    AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(ctl_q)); // R1
endmodule

// File: rtl/t1ei_arm_cell.sv
// One pending-request flag: set by arm, cleared by hit (error applied)
// or by kill (request no longer valid in the current mode).
// Assumes kill and arm are never both high in one cycle.
module t1ei_arm_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic hit_i,
    input  logic kill_i,
    output logic pend_o
);
    logic pend_q;

    // Track whether an error of this kind is still owed
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_q <= 1'b0;
        else if (kill_i) pend_q <= 1'b0;
        else             pend_q <= arm_i | (pend_q & ~hit_i);
    end

    assign pend_o = pend_q;

    AST_ARM_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(arm_i)); // R1
    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && !arm_i) |=> !pend_q); // R7
endmodule

// File: rtl/t1ei_target.sv
// Works out which requests arm, which are dropped by mode, and which
// hit their bit position this cycle. Assumes at most one position strobe
// per bit; strobes are ignored unless bit_vld is high.
module t1ei_target
    import t1ei_pkg::*;
(
    input  req_vec_t rise_i,
    input  req_vec_t pend_i,
    input  logic     esf_i,
    input  logic     los_i,
    input  logic     bit_vld_i,
    input  logic     bit_in_i,
    input  logic     fbit_stb_i,
    input  logic     sbit_stb_i,
    input  logic     crc_stb_i,
    input  logic     pay_stb_i,
    output req_vec_t arm_o,
    output req_vec_t kill_o,
    output req_vec_t hit_o,
    output logic     flip_o
);
    logic live;

    // Mode gating of new requests
    always_comb begin
        arm_o          = rise_i;
        arm_o[REQ_CRC] = rise_i[REQ_CRC] & esf_i;
        arm_o[REQ_FS]  = rise_i[REQ_FS] & ~esf_i;
    end

    // Drop pending framing requests that no longer fit the mode
    always_comb begin
        kill_o          = '0;
        kill_o[REQ_CRC] = ~esf_i;
        kill_o[REQ_FS]  = esf_i;
    end

    // Match pending requests to the bit now passing
    always_comb begin
        live           = bit_vld_i & ~los_i;
        hit_o          = '0;
        hit_o[REQ_BPV] = pend_i[REQ_BPV] & live & bit_in_i;
        hit_o[REQ_CRC] = pend_i[REQ_CRC] & live & crc_stb_i & esf_i;
        hit_o[REQ_FT]  = pend_i[REQ_FT]  & live & fbit_stb_i;
        hit_o[REQ_FS]  = pend_i[REQ_FS]  & live & sbit_stb_i & ~esf_i;
        hit_o[REQ_PAY] = pend_i[REQ_PAY] & live & pay_stb_i;
        flip_o = hit_o[REQ_CRC] | hit_o[REQ_FT] | hit_o[REQ_FS] | hit_o[REQ_PAY];
    end
endmodule

// File: rtl/t1ei_out_stage.sv
// Applies the inversion, the violation flag and loss-of-signal forcing.
// OUT_PIPE = 1 registers the outputs (one cycle latency); 0 is combinational.
module t1ei_out_stage #(
    parameter bit OUT_PIPE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vld_i,
    input  logic bit_i,
    input  logic flip_i,
    input  logic bpv_i,
    input  logic los_i,
    output logic vld_o,
    output logic bit_o,
    output logic bpv_o,
    output logic zcs_off_o
);
    logic n_vld, n_bit, n_bpv, n_zcs;

    // Next output values, with loss of signal taking precedence
    always_comb begin
        n_vld = vld_i;
        n_bit = vld_i & ~los_i & (bit_i ^ flip_i);
        n_bpv = vld_i & ~los_i & bpv_i;
        n_zcs = vld_i & los_i;
    end

    generate
        if (OUT_PIPE) begin : g_reg
            logic r_vld, r_bit, r_bpv, r_zcs;
            // Register the outputs toward the line coder
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    r_vld <= 1'b0; r_bit <= 1'b0; r_bpv <= 1'b0; r_zcs <= 1'b0;
                end else begin
                    r_vld <= n_vld; r_bit <= n_bit; r_bpv <= n_bpv; r_zcs <= n_zcs;
                end
            end
            assign vld_o = r_vld;
            assign bit_o = r_bit;
            assign bpv_o = r_bpv;
            assign zcs_off_o = r_zcs;

            AST_LOS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
                (vld_i && los_i) |=> (vld_o && !bit_o && !bpv_o && zcs_off_o)); // R8
            AST_ONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
                vld_i |=> vld_o); // R9
        end else begin : g_comb
            logic unused_clk;
            assign unused_clk = clk ^ rst_n;
            assign vld_o = n_vld;
            assign bit_o = n_bit;
            assign bpv_o = n_bpv;
            assign zcs_off_o = n_zcs;
        end
    endgenerate
endmodule

// File: rtl/t1_err_inject.sv
// Top of the T1 transmit error injector. Assumes framer strobes arrive in
// the same cycle as the bit they mark, and that control writes last one cycle.
module t1_err_inject
    import t1ei_pkg::*;
#(
    parameter int CTL_BITS = CTL_W,
    parameter bit OUT_PIPE = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [CTL_BITS-1:0] cfg_wdata,
    input  logic                esf_mode,
    input  logic                bit_vld,
    input  logic                bit_in,
    input  logic                fbit_stb,
    input  logic                sbit_stb,
    input  logic                crc_stb,
    input  logic                pay_stb,
    output logic                out_vld,
    output logic                out_bit,
    output logic                out_bpv,
    output logic                out_zcs_off
);
    localparam int HI_W = CTL_BITS - CTL_LOS - 1;

    logic [CTL_BITS-1:0] ctl, rise;
    req_vec_t arm, kill, hit, pend;
    logic flip;
    logic unused_hi;

    t1ei_ctl_reg #(.W(CTL_BITS)) ctl_i (
        .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .wdata_i(cfg_wdata),
        .ctl_o(ctl), .rise_o(rise)
    );

    // Spare control bits carry no function
    assign unused_hi = ^{ctl[CTL_BITS-1 -: HI_W], rise[CTL_BITS-1 -: HI_W + 1]};

    t1ei_target tgt_i (
        .rise_i(rise[NREQ-1:0]), .pend_i(pend), .esf_i(esf_mode),
        .los_i(ctl[CTL_LOS]), .bit_vld_i(bit_vld), .bit_in_i(bit_in),
        .fbit_stb_i(fbit_stb), .sbit_stb_i(sbit_stb), .crc_stb_i(crc_stb),
        .pay_stb_i(pay_stb), .arm_o(arm), .kill_o(kill), .hit_o(hit),
        .flip_o(flip)
    );

    generate
        for (genvar g = 0; g < NREQ; g++) begin : g_cell
            t1ei_arm_cell cell_i (
                .clk(clk), .rst_n(rst_n), .arm_i(arm[g]), .hit_i(hit[g]),
                .kill_i(kill[g]), .pend_o(pend[g])
            );
        end
    endgenerate

    t1ei_out_stage #(.OUT_PIPE(OUT_PIPE)) out_i (
        .clk(clk), .rst_n(rst_n), .vld_i(bit_vld), .bit_i(bit_in),
        .flip_i(flip), .bpv_i(hit[REQ_BPV]), .los_i(ctl[CTL_LOS]),
        .vld_o(out_vld), .bit_o(out_bit), .bpv_o(out_bpv),
        .zcs_off_o(out_zcs_off)
    );

    AST_CRC_ESF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !esf_mode |=> !pend[REQ_CRC]); // R3
    AST_FS_D4_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        esf_mode |=> !pend[REQ_FS]); // R5
    AST_FT_USED: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[REQ_FT] && bit_vld && fbit_stb && !ctl[CTL_LOS] && !arm[REQ_FT])
        |=> !pend[REQ_FT]); // R4
    AST_PAY_USED: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[REQ_PAY] && bit_vld && pay_stb && !ctl[CTL_LOS] && !arm[REQ_PAY])
        |=> !pend[REQ_PAY]); // R6
endmodule

// File: tb/t1_err_inject_tb.sv
module t1_err_inject_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic esf_mode = 1'b0;
    logic bit_vld = 1'b0, bit_in = 1'b0;
    logic fbit_stb = 1'b0, sbit_stb = 1'b0, crc_stb = 1'b0, pay_stb = 1'b0;
    logic out_vld, out_bit, out_bpv, out_zcs_off;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // expected {bit, bpv, zcs_off} and requirement tag, one per sent bit
    logic [2:0] exp_q[$];
    string tag_q[$];

    // requirement-level model state
    logic [7:0] m_ctl = '0;
    bit p_bpv, p_crc, p_ft, p_fs, p_pay;

    always #2 clk = ~clk;

    t1_err_inject dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .esf_mode(esf_mode), .bit_vld(bit_vld), .bit_in(bit_in),
        .fbit_stb(fbit_stb), .sbit_stb(sbit_stb), .crc_stb(crc_stb),
        .pay_stb(pay_stb), .out_vld(out_vld), .out_bit(out_bit),
        .out_bpv(out_bpv), .out_zcs_off(out_zcs_off)
    );

    task automatic chk(input bit ok, input string tag, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] w);
        logic [7:0] r;
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = w;
        r = w & ~m_ctl;
        if (r[0]) p_bpv = 1;
        if (r[1] && esf_mode) p_crc = 1;
        if (r[2]) p_ft = 1;
        if (r[3] && !esf_mode) p_fs = 1;
        if (r[4]) p_pay = 1;
        m_ctl = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_mode(input bit m);
        @(negedge clk);
        esf_mode = m;
        if (m) p_fs = 0;
        else   p_crc = 0;
        @(negedge clk);
    endtask

    // driver: send one bit, push its expected output
    task automatic sb(input bit b, input bit f, input bit s, input bit c, input bit p, input string tag);
        logic [2:0] e;
        bit fl;
        @(negedge clk);
        bit_vld = 1; bit_in = b; fbit_stb = f; sbit_stb = s; crc_stb = c; pay_stb = p;
        if (m_ctl[5]) begin
            e = 3'b001;
        end else begin
            fl = 0;
            if (p_ft && f) begin fl = 1; p_ft = 0; end
            if (p_fs && s && !esf_mode) begin fl = 1; p_fs = 0; end
            if (p_crc && c && esf_mode) begin fl = 1; p_crc = 0; end
            if (p_pay && p) begin fl = 1; p_pay = 0; end
            e = {b ^ fl, p_bpv && b, 1'b0};
            if (p_bpv && b) p_bpv = 0;
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        bit_vld = 0; fbit_stb = 0; sbit_stb = 0; crc_stb = 0; pay_stb = 0;
    endtask

    // monitor: compare each produced bit against the scoreboard
    always @(negedge clk) begin
        if (rst_n && out_vld) begin
            if (exp_q.size() == 0) begin
                chk(0, "R9 unexpected output", {out_bit, out_bpv, out_zcs_off}, 3'b000);
            end else begin
                logic [2:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({out_bit, out_bpv, out_zcs_off} === e, t, {out_bit, out_bpv, out_zcs_off}, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({out_vld, out_bit, out_bpv, out_zcs_off} === 4'b0, "R9 reset state",
            {out_bit, out_bpv, out_zcs_off}, 3'b000);

        // R9: clean pass-through
        sb(1, 0, 0, 0, 1, "R9 passthrough");
        sb(0, 0, 0, 0, 1, "R9 passthrough");
        sb(1, 1, 0, 0, 0, "R9 passthrough");

        // R2: violation waits for a mark
        wr(8'h01);
        sb(0, 0, 0, 0, 1, "R2 zero bit keeps violation");
        sb(0, 0, 0, 0, 1, "R2 zero bit keeps violation");
        sb(1, 0, 0, 0, 1, "R2 violation on mark");
        sb(1, 0, 0, 0, 1, "R2 only one violation");
        // R1: steady one and falling writes do nothing
        wr(8'h01);
        sb(1, 0, 0, 0, 1, "R1 steady write no effect");
        wr(8'h00);
        sb(1, 0, 0, 0, 1, "R1 falling write no effect");

        // R6 and R7: payload flips once, repeated rises still one error
        wr(8'h10);
        sb(1, 0, 0, 0, 1, "R6 payload flipped");
        sb(1, 0, 0, 0, 1, "R6 next payload clean");
        wr(8'h00); wr(8'h10); wr(8'h00); wr(8'h10);
        sb(0, 0, 0, 0, 1, "R7 single error after repeats");
        sb(0, 0, 0, 0, 1, "R7 no second error");
        wr(8'h00);

        // R4: terminal framing in D4, not on Fs bits
        wr(8'h04);
        sb(1, 0, 1, 0, 0, "R4 Fs bit untouched");
        sb(1, 1, 0, 0, 0, "R4 Ft bit flipped");
        sb(1, 1, 0, 0, 0, "R4 once only");
        wr(8'h00);

        // R5: Fs in D4
        wr(8'h08);
        sb(0, 1, 0, 0, 0, "R5 Ft bit untouched");
        sb(0, 0, 1, 0, 0, "R5 Fs flipped");
        wr(8'h00);

        // R3: CRC request in D4 is discarded
        wr(8'h02);
        sb(1, 0, 0, 1, 0, "R3 D4 request ignored");
        wr(8'h00);
        set_mode(1);
        sb(1, 0, 0, 1, 0, "R3 not held across mode");

        // R5: Fs request in ESF discarded
        wr(8'h08);
        sb(1, 0, 1, 0, 0, "R5 ESF request ignored");
        wr(8'h00);

        // R3: CRC in ESF
        wr(8'h02);
        sb(0, 0, 0, 0, 1, "R3 payload untouched");
        sb(0, 0, 0, 1, 0, "R3 CRC bit flipped");
        sb(0, 0, 0, 1, 0, "R3 once only");
        // R3: pending CRC dropped on leaving ESF
        wr(8'h00); wr(8'h02);
        set_mode(0);
        set_mode(1);
        sb(1, 0, 0, 1, 0, "R3 dropped on mode change");
        wr(8'h00);

        // R4: ESF framing pattern bit
        wr(8'h04);
        sb(0, 1, 0, 0, 0, "R4 ESF pattern bit flipped");
        wr(8'h00);
        set_mode(0);

        // R8: loss of signal forces zeros and holds requests
        wr(8'h31);
        sb(1, 0, 0, 0, 1, "R8 forced zero");
        sb(1, 1, 0, 0, 0, "R8 forced zero");
        wr(8'h11);
        sb(1, 0, 0, 0, 1, "R8 held payload error applied");

        // R10: spare bits do nothing
        wr(8'h00);
        wr(8'hC0);
        sb(1, 0, 0, 0, 1, "R10 spare bits ignored");
        sb(0, 1, 0, 0, 0, "R10 spare bits ignored");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R9 all bits emerged", 3'(exp_q.size()), 3'b000);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule